// File: doc/BRIEF.md
# UART Interrupt Request Generator

This block turns transmit and receive buffer events of a UART into one shared interrupt request for the interrupt controller. The transmitter reports each move of a buffered word into its shift register. The receiver reports each word it loads into its two-entry receive buffer. The block also sees CPU writes to the transmit data register, CPU reads of the receive data register, and a receive-error strobe together with its own enable. From these inputs it keeps three readable status flags: transmit buffer empty, receive data ready and second word buffered.

A control register holds the per-source enables and a threshold bit. The threshold bit selects whether the receive request fires on the first buffered word or on the second. Every enabled source drives the same output, which is a one-cycle pulse. Software reads the status flags to find out which source raised the request.

Top module: `uart_irq_gen`

## Requirements
- R1: `irq` is a registered one-cycle pulse. It is high in the cycle after a clock edge at which at least one enabled source event was sampled, and low otherwise. Events from several sources at the same edge give one pulse.
- R2: `ctl_rdata` bit 1 is the receive threshold, bit 4 is the transmit-empty enable and bit 5 is the receive-full enable. All reset to 0 and all other bits read 0. A `ctl_we` write is visible from the next cycle. Events at the same edge as the write are gated by the old value.
- R3: `stat_rdata` bit 0 is the transmit-empty flag. It resets to 1, is set by `tx_load` and is cleared by `txd_we`. When both come at the same edge, `tx_load` wins.
- R4: A transmit event is a `tx_load` that finds the flag at 0. It pulses `irq` only when control bit 4 is 1.
- R5: The receive buffer holds 0 to 2 words. `stat_rdata` bit 1 is 1 when at least one word is held, and bit 3 is 1 when two words are held. `rxd_re` removes a word and is ignored when the buffer is empty. `rx_push` adds a word and is ignored when the buffer is full. When both come at the same edge, the removal is applied first.
- R6: With control bit 1 at 0, a receive event is the ready flag (bit 1) going from 0 to 1.
- R7: With control bit 1 at 1, a receive event is the second-word flag (bit 3) going from 0 to 1. Loading the first word gives no request.
- R8: With control bit 5 at 0, receive events produce no request.
- R9: `err_strobe` produces a request only when `err_en` is 1.
- R10: The status register is read-only. `stat_we` changes nothing, and the status bits other than 0, 1 and 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Write strobe for the control register |
| stat_we | input | 1 | Write strobe for the status register (ignored) |
| wdata | input | DATA_W | Register write data |
| ctl_rdata | output | DATA_W | Control register value |
| stat_rdata | output | DATA_W | Status register value |
| txd_we | input | 1 | CPU wrote the transmit data register |
| rxd_re | input | 1 | CPU read the receive data register |
| tx_load | input | 1 | Transmit word moved into the shift register |
| rx_push | input | 1 | Received word loaded into the buffer |
| err_strobe | input | 1 | Receive error event |
| err_en | input | 1 | Enable for the receive error request |
| irq | output | 1 | Shared interrupt request pulse |

## Verification
Every flag and the control register change at the clock edge that samples their strobe. They can be read on `stat_rdata` or `ctl_rdata` from that edge on. The `irq` pulse for an event sampled at edge k is high only between edge k and edge k+1. The bench therefore drives each strobe just after a falling edge, lets one rising edge pass, and compares all outputs at the next falling edge against a model stepped at that same rising edge. Strobes are cleared after each comparison, so every pulse is checked both for its presence and for its one-cycle width.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int CTL_THR_BIT  = 1;
   localparam int CTL_TXEN_BIT = 4;
   localparam int CTL_RXEN_BIT = 5;
   localparam int ST_TXE_BIT   = 0;
   localparam int ST_RDY_BIT   = 1;
   localparam int ST_TWO_BIT   = 3;
   localparam int NUM_SRC      = 3;
   typedef enum int {SRC_TX = 0, SRC_RX = 1, SRC_ERR = 2} irq_src_e;
endpackage

// File: rtl/uart_irq_txflag.sv
module uart_irq_txflag (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic cpu_wr_i,
   output logic empty_o,
   output logic rise_o
);
   logic empty_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        empty_q <= 1'b1;
      else if (load_i)   empty_q <= 1'b1;
      else if (cpu_wr_i) empty_q <= 1'b0;
   end

   assign empty_o = empty_q;
   assign rise_o  = load_i & ~empty_q;

   // R3
   tx_load_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> empty_o);
   // R3
   tx_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr_i && !load_i) |=> !empty_o);
endmodule

// File: rtl/uart_irq_rxbuf.sv
module uart_irq_rxbuf #(
   parameter int DEPTH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic push_i,
   input  logic pop_i,
   input  logic two_word_i,
   output logic ready_o,
   output logic second_o,
   output logic event_o
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   generate
      if (DEPTH != 2) begin : g_bad_depth
         $error("uart_irq_rxbuf: DEPTH must be 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q, cnt_mid, cnt_nxt;
   logic             ready_nxt, second_nxt;

   always_comb begin
      cnt_mid = (pop_i && cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
      cnt_nxt = (push_i && cnt_mid != FULL) ? cnt_mid + 1'b1 : cnt_mid;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nxt;
   end

   assign ready_o    = (cnt_q != '0);
   assign second_o   = (cnt_q == FULL);
   assign ready_nxt  = (cnt_nxt != '0);
   assign second_nxt = (cnt_nxt == FULL);
   assign event_o    = two_word_i ? (second_nxt & ~second_o)
                                  : (ready_nxt & ~ready_o);

   // R5
   second_implies_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      second_o |-> ready_o);
   // R5
   push_makes_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i) |=> ready_o);
endmodule

// File: rtl/uart_irq_merge.sv
module uart_irq_merge #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt_i,
   input  logic [N-1:0] en_i,
   output logic         irq_o
);
   logic [N-1:0] gated;

   generate
      if (N < 1) begin : g_bad_n
         $error("uart_irq_merge: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_gate
         assign gated[i] = evt_i[i] & en_i[i];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= |gated;
   end
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
   import uart_irq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic              stat_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctl_rdata,
   output logic [DATA_W-1:0] stat_rdata,
   input  logic              txd_we,
   input  logic              rxd_re,
   input  logic              tx_load,
   input  logic              rx_push,
   input  logic              err_strobe,
   input  logic              err_en,
   output logic              irq
);
   generate
      if (DATA_W < 6) begin : g_bad_width
         $error("uart_irq_gen: DATA_W must be at least 6");
      end
   endgenerate

   localparam logic [DATA_W-1:0] CTL_MASK =
      (DATA_W'(1) << CTL_THR_BIT) | (DATA_W'(1) << CTL_TXEN_BIT) |
      (DATA_W'(1) << CTL_RXEN_BIT);

   logic [DATA_W-1:0] ctl_q;
   logic              tx_empty, tx_rise;
   logic              rx_ready, rx_second, rx_evt;
   logic [NUM_SRC-1:0] evt, en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (ctl_we) ctl_q <= wdata & CTL_MASK;
   end

   uart_irq_txflag u_tx (
      .clk(clk), .rst_n(rst_n), .load_i(tx_load), .cpu_wr_i(txd_we),
      .empty_o(tx_empty), .rise_o(tx_rise)
   );

   uart_irq_rxbuf #(.DEPTH(2)) u_rx (
      .clk(clk), .rst_n(rst_n), .push_i(rx_push), .pop_i(rxd_re),
      .two_word_i(ctl_q[CTL_THR_BIT]), .ready_o(rx_ready),
      .second_o(rx_second), .event_o(rx_evt)
   );

   always_comb begin
      evt          = '0;
      en           = '0;
      evt[SRC_TX]  = tx_rise;
      en[SRC_TX]   = ctl_q[CTL_TXEN_BIT];
      evt[SRC_RX]  = rx_evt;
      en[SRC_RX]   = ctl_q[CTL_RXEN_BIT];
      evt[SRC_ERR] = err_strobe;
      en[SRC_ERR]  = err_en;
   end

   uart_irq_merge #(.N(NUM_SRC)) u_merge (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .en_i(en), .irq_o(irq)
   );

   always_comb begin
      stat_rdata             = '0;
      stat_rdata[ST_TXE_BIT] = tx_empty;
      stat_rdata[ST_RDY_BIT] = rx_ready;
      stat_rdata[ST_TWO_BIT] = rx_second;
   end
   assign ctl_rdata = ctl_q;

   // R1
   no_stray_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_load || rx_push || (err_strobe && err_en)) |=> !irq);
   // R8
   rx_disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_rdata[CTL_RXEN_BIT] && !tx_load && !(err_strobe && err_en)) |=> !irq);
   // R10
   stat_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_we && !tx_load && !txd_we && !rx_push && !rxd_re) |=> $stable(stat_rdata));
endmodule

// File: tb/sim_uart_irq_gen.sv
module sim_uart_irq_gen;
   localparam int  DW = 8;
   localparam time TCLK = 10ns;

   logic clk = 0, rst_n = 0;
   logic ctl_we = 0, stat_we = 0, txd_we = 0, rxd_re = 0;
   logic tx_load = 0, rx_push = 0, err_strobe = 0, err_en = 0;
   logic [DW-1:0] wdata = '0, ctl_rdata, stat_rdata;
   logic irq;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   logic [DW-1:0] m_ctl;
   logic          m_tx, m_irq;
   int            m_cnt;

   always #(TCLK/2) clk = ~clk;

   uart_irq_gen #(.DATA_W(DW)) u0 (.*);

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] exp_stat();
      logic [DW-1:0] s = '0;
      s[0] = m_tx; s[1] = (m_cnt >= 1); s[3] = (m_cnt == 2);
      return s;
   endfunction

   task automatic model_step();
      int mid, nxt;
      logic ev_tx, ev_rx;
      ev_tx = tx_load && !m_tx;
      mid = (rxd_re && m_cnt > 0) ? m_cnt - 1 : m_cnt;
      nxt = (rx_push && mid < 2) ? mid + 1 : mid;
      ev_rx = m_ctl[1] ? (m_cnt < 2 && nxt == 2) : (m_cnt == 0 && nxt >= 1);
      m_irq = (ev_tx && m_ctl[4]) || (ev_rx && m_ctl[5]) || (err_strobe && err_en);
      if (tx_load) m_tx = 1'b1; else if (txd_we) m_tx = 1'b0;
      m_cnt = nxt;
      if (ctl_we) m_ctl = wdata & 8'h32;
   endtask

   // called just after a falling edge with inputs set
   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk("R1 irq", {7'b0, irq}, {7'b0, m_irq});
      chk("R2 ctl", ctl_rdata, m_ctl);
      chk("R3 txe", {7'b0, stat_rdata[0]}, {7'b0, m_tx});
      chk("R5 rx flags", stat_rdata & 8'h0A, exp_stat() & 8'h0A);
      chk("R10 stat", stat_rdata, exp_stat());
      ctl_we = 0; stat_we = 0; txd_we = 0; rxd_re = 0;
      tx_load = 0; rx_push = 0; err_strobe = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      m_ctl = '0; m_tx = 1'b1; m_cnt = 0; m_irq = 0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic wr_ctl(input logic [DW-1:0] v);
      ctl_we = 1; wdata = v; tick();
   endtask

   initial begin
      int seed;
      seed = 7;
      void'($urandom(seed));
      do_reset();
      // reset state R2 R3 R10
      chk("R2 reset ctl", ctl_rdata, 8'h00);
      chk("R3 reset stat", stat_rdata, 8'h01);
      chk("R1 reset irq", {7'b0, irq}, 8'h00);

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         ctl_we     = ($urandom_range(0, 15) == 0);
         wdata      = DW'($urandom);
         stat_we    = ($urandom_range(0, 7) == 0);
         txd_we     = ($urandom_range(0, 3) == 0);
         tx_load    = ($urandom_range(0, 3) == 0);
         rx_push    = ($urandom_range(0, 2) == 0);
         rxd_re     = ($urandom_range(0, 3) == 0);
         err_strobe = ($urandom_range(0, 9) == 0);
         err_en     = $urandom_range(0, 1);
         tick();
      end

      // R4: transmit enable on/off
      do_reset();
      txd_we = 1; tick(); tx_load = 1; tick();
      chk("R4 tx disabled", {7'b0, irq}, 8'h00);
      wr_ctl(8'h10);
      txd_we = 1; tick(); tx_load = 1; tick();
      chk("R4 tx pulse", {7'b0, irq}, 8'h01);
      tick();
      chk("R4 pulse width", {7'b0, irq}, 8'h00);
      tx_load = 1; tick();
      chk("R4 no rise no pulse", {7'b0, irq}, 8'h00);

      // R6: threshold one word
      do_reset();
      wr_ctl(8'hFF);
      chk("R2 masked write", ctl_rdata, 8'h32);
      wr_ctl(8'h20);
      rx_push = 1; tick();
      chk("R6 first word", {7'b0, irq}, 8'h01);
      rx_push = 1; tick();
      chk("R6 second word quiet", {7'b0, irq}, 8'h00);

      // R7: threshold two words, buffer limits R5
      do_reset();
      wr_ctl(8'h22);
      rx_push = 1; tick();
      chk("R7 first word quiet", {7'b0, irq}, 8'h00);
      rx_push = 1; tick();
      chk("R7 second word", {7'b0, irq}, 8'h01);
      rx_push = 1; tick();
      chk("R5 full push ignored", stat_rdata, 8'h0B);
      chk("R7 overflow quiet", {7'b0, irq}, 8'h00);
      rxd_re = 1; rx_push = 1; tick();
      chk("R5 pop+push full", stat_rdata, 8'h0B);
      rxd_re = 1; tick();
      chk("R5 pop one", stat_rdata, 8'h03);
      rxd_re = 1; tick();
      rxd_re = 1; tick();
      chk("R5 pop empty ignored", stat_rdata, 8'h01);

      // R8: receive disabled
      do_reset();
      wr_ctl(8'h12);
      rx_push = 1; tick(); rx_push = 1; tick();
      chk("R8 rx disabled", {7'b0, irq}, 8'h00);

      // R2: write and event at same edge use old enable
      do_reset();
      ctl_we = 1; wdata = 8'h20; rx_push = 1; tick();
      chk("R2 old enable gates", {7'b0, irq}, 8'h00);

      // R9: error gating
      do_reset();
      err_strobe = 1; err_en = 0; tick();
      chk("R9 error disabled", {7'b0, irq}, 8'h00);
      err_strobe = 1; err_en = 1; tick();
      chk("R9 error enabled", {7'b0, irq}, 8'h01);
      err_en = 0;

      // R10: status write ignored
      do_reset();
      stat_we = 1; wdata = 8'hFF; tick();
      chk("R10 stat write", stat_rdata, 8'h01);

      // R1: merged sources
      do_reset();
      wr_ctl(8'h30);
      txd_we = 1; tick();
      tx_load = 1; rx_push = 1; err_strobe = 1; err_en = 1; tick();
      chk("R1 merged pulse", {7'b0, irq}, 8'h01);
      err_en = 0; tick();
      chk("R1 single cycle", {7'b0, irq}, 8'h00);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule